// File: doc/BRIEF.md
# Link Synchronization Tracker for Coded Word Streams

This block decides whether a receive lane carrying 10-bit coded words is in sync. It sits after the word aligner and the line decoder. Every cycle it sees a strobe that marks a new word, two flags from the decoder (an illegal code, and a running-disparity violation), and a flag that marks a word holding a comma character. From these it keeps one of three states: hunting, acquiring and locked. It reports a registered sync flag and the current error count.

Lock is gained after a programmed number of back-to-back clean comma words. Lock is lost through a leaky error counter. Each error event adds one to the counter. Each unbroken run of a programmed number of clean words takes one away, and the counter never goes below zero. When the count reaches the programmed loss limit, the lane drops back to hunting.

The three thresholds are inputs. They hold the count minus one, so a field of 0 to 255 selects 1 to 256. They must not change while the block is out of reset.

Top module: `wa_sync_fsm`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, the state output is 0 (hunting), sync_o is low and err_cnt_o is 0.
- R2: In the hunting or acquiring state, after acq_cfg_i+1 consecutive valid words that carry a comma and have neither error flag set, the state becomes 2 (locked). The state output takes the value 1 (acquiring) while the run is in progress.
- R3: In the acquiring state, a valid word that has an error flag set or carries no comma returns the state to 0 and restarts the acquisition run from zero. In the hunting state, such a word leaves the state at 0.
- R4: In the locked state, a valid word with code_err_i or disp_err_i set adds exactly one to err_cnt_o. A word with both flags set still adds only one. Either flag also restarts the run of good words.
- R5: In the locked state, when an error event brings err_cnt_o to loss_cfg_i+1, the state returns to 0 and sync_o falls in the next cycle. err_cnt_o keeps that value until the next lock.
- R6: In the locked state, each run of decr_cfg_i+1 consecutive valid error-free words lowers err_cnt_o by one and then starts a new run.
- R7: A completed good-word run while err_cnt_o is 0 leaves err_cnt_o at 0 and still starts a new run.
- R8: A cycle with word_vld_i low changes nothing: the state, the error count and the acquisition and good-word runs all hold.
- R9: On entering the locked state, err_cnt_o and the good-word run are cleared to zero.
- R10: sync_o is a register output. It goes high in the cycle after the word that completes acquisition, and it is high exactly when the state is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld_i | input | 1 | A new decoded word is present this cycle |
| code_err_i | input | 1 | The word held an illegal code |
| disp_err_i | input | 1 | The word broke running disparity |
| comma_i | input | 1 | The word carries a comma character |
| loss_cfg_i | input | CFG_W | Loss limit minus one (1 to 256 error events) |
| decr_cfg_i | input | CFG_W | Good-run length minus one for each decrement |
| acq_cfg_i | input | CFG_W | Clean comma words needed for lock, minus one |
| sync_o | output | 1 | Lane is locked |
| state_o | output | 2 | 0 hunting, 1 acquiring, 2 locked |
| err_cnt_o | output | CFG_W+1 | Current leaky error count |

## Verification
The bench sweeps small limits, windows and acquisition lengths. For each setting it drives error-biased word streams and checks every cycle against an arithmetic model.

It aims at five corner cases:
- A cycle with both error flags set. A design that counts two events here loses lock early.
- A good run that completes while the counter is at zero. A design that gets this wrong wraps the counter to its maximum and drops lock at once.
- A limit of one. Here the very first error must break lock.
- Gaps in the valid strobe inside an acquisition or good run. A design that lets these advance the runs or break them locks or decrements at the wrong cycle.
- The widest settings: 256 errors to lose lock and 256 comma words to gain it. These expose a counter that is one bit too narrow.

// File: rtl/wsync_pkg.sv
package wsync_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2
    } link_state_e;

endpackage

// File: rtl/ws_classify.sv
module ws_classify (
    input  logic word_vld_i,
    input  logic code_err_i,
    input  logic disp_err_i,
    input  logic comma_i,
    output logic ev_err_o,
    output logic ev_good_o,
    output logic ev_comma_o,
    output logic ev_break_o
);

    logic any_err;

    always_comb begin
        any_err    = code_err_i | disp_err_i;
        // Two flags on one word are one event.
        ev_err_o   = word_vld_i & any_err;
        ev_good_o  = word_vld_i & ~any_err;
        ev_comma_o = word_vld_i & ~any_err & comma_i;
        ev_break_o = word_vld_i & ~(~any_err & comma_i);
    end

endmodule

// File: rtl/ws_acq_count.sv
module ws_acq_count #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             ev_comma_i,
    input  logic             ev_break_i,
    input  logic [CFG_W-1:0] need_cfg_i,
    output logic             done_o
);

    typedef struct packed {
        logic [CFG_W-1:0] run;
    } acq_regs_t;

    acq_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        done_o = active_i & ev_comma_i & (r_q.run == need_cfg_i);
        if (active_i) begin
            if (done_o) begin
                r_d.run = '0;
            end else if (ev_comma_i) begin
                r_d.run = r_q.run + 1'b1;
            end else if (ev_break_i) begin
                r_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: the run never passes the programmed length
    a_r2_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.run <= need_cfg_i);

    // R8: idle cycles leave the run untouched
    a_r8_acq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_comma_i && !ev_break_i) |=> $stable(r_q.run));

endmodule

// File: rtl/ws_leaky_count.sv
module ws_leaky_count #(
    parameter int CFG_W = 8,
    localparam int CNT_W = CFG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             clear_i,
    input  logic             ev_err_i,
    input  logic             ev_good_i,
    input  logic [CFG_W-1:0] loss_cfg_i,
    input  logic [CFG_W-1:0] decr_cfg_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CFG_W-1:0] run;
    } leak_regs_t;

    leak_regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        hit_o = active_i & ev_err_i & (r_q.cnt == {1'b0, loss_cfg_i});
        if (clear_i) begin
            r_d.cnt = '0;
            r_d.run = '0;
        end else if (active_i) begin
            if (ev_err_i) begin
                r_d.cnt = r_q.cnt + 1'b1;
                r_d.run = '0;
            end else if (ev_good_i) begin
                if (r_q.run == decr_cfg_i) begin
                    r_d.run = '0;
                    if (r_q.cnt != '0) begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end else begin
                    r_d.run = r_q.run + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o = r_q.cnt;

    // R4: one error event raises the count by exactly one
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && ev_err_i && !clear_i) |=> (r_q.cnt == $past(r_q.cnt) + 1'b1));

    // R7: no wrap below zero
    a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && ev_good_i && !clear_i && r_q.cnt == '0) |=> (r_q.cnt == '0));

    // R5: while locked the count stays under the limit
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (r_q.cnt <= {1'b0, loss_cfg_i}));

endmodule

// File: rtl/wa_sync_fsm.sv
module wa_sync_fsm
    import wsync_pkg::*;
#(
    parameter int CFG_W = 8,
    localparam int CNT_W = CFG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld_i,
    input  logic             code_err_i,
    input  logic             disp_err_i,
    input  logic             comma_i,
    input  logic [CFG_W-1:0] loss_cfg_i,
    input  logic [CFG_W-1:0] decr_cfg_i,
    input  logic [CFG_W-1:0] acq_cfg_i,
    output logic             sync_o,
    output logic [1:0]       state_o,
    output logic [CNT_W-1:0] err_cnt_o
);

    typedef struct packed {
        link_state_e st;
        logic        sync;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic ev_err, ev_good, ev_comma, ev_break;
    logic acq_done, loss_hit, lock_entry;
    logic is_locked;

    ws_classify u_classify (
        .word_vld_i (word_vld_i),
        .code_err_i (code_err_i),
        .disp_err_i (disp_err_i),
        .comma_i    (comma_i),
        .ev_err_o   (ev_err),
        .ev_good_o  (ev_good),
        .ev_comma_o (ev_comma),
        .ev_break_o (ev_break)
    );

    assign is_locked = (r_q.st == ST_LOCK);

    ws_acq_count #(.CFG_W(CFG_W)) u_acq (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (~is_locked),
        .ev_comma_i (ev_comma),
        .ev_break_i (ev_break),
        .need_cfg_i (acq_cfg_i),
        .done_o     (acq_done)
    );

    ws_leaky_count #(.CFG_W(CFG_W)) u_leak (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (is_locked),
        .clear_i    (lock_entry),
        .ev_err_i   (ev_err),
        .ev_good_i  (ev_good),
        .loss_cfg_i (loss_cfg_i),
        .decr_cfg_i (decr_cfg_i),
        .cnt_o      (err_cnt_o),
        .hit_o      (loss_hit)
    );

    always_comb begin
        r_d        = r_q;
        lock_entry = 1'b0;
        unique case (r_q.st)
            ST_HUNT: begin
                if (acq_done) begin
                    r_d.st     = ST_LOCK;
                    lock_entry = 1'b1;
                end else if (ev_comma) begin
                    r_d.st = ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (acq_done) begin
                    r_d.st     = ST_LOCK;
                    lock_entry = 1'b1;
                end else if (ev_break) begin
                    r_d.st = ST_HUNT;
                end
            end
            ST_LOCK: begin
                if (loss_hit) begin
                    r_d.st = ST_HUNT;
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
        r_d.sync = (r_d.st == ST_LOCK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_HUNT, sync: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_o  = r_q.sync;
    assign state_o = r_q.st;

    // R8: no word, no change
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_i |=> ($stable(state_o) && $stable(err_cnt_o)));

    // R5: hitting the limit drops sync on the next cycle
    a_r5_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && word_vld_i && (code_err_i || disp_err_i) && err_cnt_o == {1'b0, loss_cfg_i})
        |=> (!sync_o && state_o == 2'd0));

    // R9: count is zero on the first locked cycle
    a_r9_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> (err_cnt_o == '0));

    // R3: a broken acquisition run falls back to hunting
    a_r3_acq_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && word_vld_i && (code_err_i || disp_err_i || !comma_i)) |=> (state_o == 2'd0));

endmodule

// File: tb/test_wa_sync_fsm.sv
module test_wa_sync_fsm;

    localparam int CFG_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_vld_i = 1'b0, code_err_i = 1'b0, disp_err_i = 1'b0, comma_i = 1'b0;
    logic [CFG_W-1:0] loss_cfg_i = '0, decr_cfg_i = '0, acq_cfg_i = '0;
    logic sync_o;
    logic [1:0] state_o;
    logic [CFG_W:0] err_cnt_o;

    always #10 clk = ~clk;

    wa_sync_fsm #(.CFG_W(CFG_W)) i_wa_sync_fsm (
        .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld_i), .code_err_i(code_err_i),
        .disp_err_i(disp_err_i), .comma_i(comma_i), .loss_cfg_i(loss_cfg_i),
        .decr_cfg_i(decr_cfg_i), .acq_cfg_i(acq_cfg_i),
        .sync_o(sync_o), .state_o(state_o), .err_cnt_o(err_cnt_o)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 0;
    int L, W, A;
    int m_st, m_acq, m_cnt, m_run;
    logic [31:0] lfsr = 32'h1ace_b00c;

    task automatic check(input string tag);
        bit exp_sync;
        exp_sync = (m_st == 2);
        n_vec++;
        if (int'(state_o) != m_st) begin
            n_bad++;
            $display("FAIL %s state: got %0d expected %0d", tag, state_o, m_st);
        end
        if (sync_o != exp_sync) begin
            n_bad++;
            $display("FAIL %s R10 sync: got %0b expected %0b", tag, sync_o, exp_sync);
        end
        if (int'(err_cnt_o) != m_cnt) begin
            n_bad++;
            $display("FAIL %s count: got %0d expected %0d", tag, err_cnt_o, m_cnt);
        end
    endtask

    // Expected behaviour from R2..R9, applied per word
    task automatic model(input bit v, input bit ce, input bit de, input bit cm);
        bit err, clean, gc;
        err = v && (ce || de);
        clean = v && !ce && !de;
        gc = clean && cm;
        if (!v) return;  // R8
        if (m_st != 2) begin
            if (gc) begin
                if (m_acq + 1 == A) begin
                    m_st = 2; m_acq = 0; m_cnt = 0; m_run = 0;  // R2, R9
                end else begin
                    m_st = 1; m_acq++;
                end
            end else begin
                m_st = 0; m_acq = 0;  // R3
            end
        end else if (err) begin
            m_cnt++; m_run = 0;  // R4
            if (m_cnt == L) m_st = 0;  // R5
        end else if (clean) begin
            m_run++;
            if (m_run == W) begin
                m_run = 0;
                if (m_cnt > 0) m_cnt--;  // R6, R7
            end
        end
    endtask

    task automatic step(input bit v, input bit ce, input bit de, input bit cm, input string tag);
        word_vld_i = v; code_err_i = ce; disp_err_i = de; comma_i = cm;
        model(v, ce, de, cm);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset(input int l, input int w, input int a);
        @(negedge clk);
        rst_n = 1'b0;
        word_vld_i = 0; code_err_i = 0; disp_err_i = 0; comma_i = 0;
        L = l; W = w; A = a;
        loss_cfg_i = CFG_W'(l - 1); decr_cfg_i = CFG_W'(w - 1); acq_cfg_i = CFG_W'(a - 1);
        m_st = 0; m_acq = 0; m_cnt = 0; m_run = 0;
        repeat (2) @(negedge clk);
        check("R1 in-reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after-reset");
    endtask

    task automatic acquire(input string tag);
        for (int i = 0; i < A; i++) step(1, 0, 0, 1, tag);
    endtask

    task automatic rand_run(input int cycles, input int errp);
        for (int i = 0; i < cycles; i++) begin
            bit v, ce, de, cm;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            v = (lfsr[2:0] != 3'd0);
            ce = 0; de = 0;
            if (int'(lfsr[7:4]) < errp) begin
                ce = lfsr[8]; de = lfsr[9];
                if (!ce && !de) ce = 1;
            end
            cm = (lfsr[12:11] != 2'd0) || m_st != 2;
            if (lfsr[15:13] == 3'd0) cm = 0;
            step(v, ce, de, cm, "R2 R3 R4 R5 R6 R8 sweep");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1, R2, R10: lock timing with gaps in the strobe (R8)
        do_reset(3, 2, 3);
        step(1, 0, 0, 1, "R2 first comma");
        step(0, 0, 0, 1, "R8 gap in acquisition");
        step(1, 0, 0, 1, "R2 second comma");
        step(1, 0, 0, 1, "R2 R10 lock");
        // R4: both flags is one event
        step(1, 1, 1, 0, "R4 dual flag");
        step(1, 0, 1, 0, "R4 disparity only");
        // R6: two good words take one away
        step(1, 0, 0, 0, "R6 run 1");
        step(0, 1, 1, 0, "R8 invalid with flags");
        step(1, 0, 0, 0, "R6 decrement");
        // R7: floor at zero
        step(1, 0, 0, 0, "R6 run");
        step(1, 0, 0, 0, "R6 to zero");
        step(1, 0, 0, 0, "R7 run");
        step(1, 0, 0, 0, "R7 floor");
        // R5: three errors lose lock
        step(1, 1, 0, 0, "R5 err1");
        step(1, 1, 0, 0, "R5 err2");
        step(1, 1, 0, 0, "R5 loss");
        step(1, 0, 0, 1, "R5 R3 reacquire start");
        step(1, 0, 0, 0, "R3 non-comma abort");
        acquire("R9 relock clear");

        // Limit of one
        do_reset(1, 1, 1);
        step(1, 0, 0, 1, "R2 single comma lock");
        step(1, 0, 1, 0, "R5 limit one");

        // Widest settings
        do_reset(256, 1, 256);
        acquire("R2 256 commas");
        for (int i = 0; i < 255; i++) step(1, 1, 0, 0, "R4 count to 255");
        step(1, 0, 0, 0, "R6 window one");
        step(1, 1, 0, 0, "R4 back to 255");
        step(1, 0, 1, 0, "R5 256th error");

        // Sweep a small configuration space
        for (int l = 1; l <= 4; l++)
            for (int w = 1; w <= 3; w++)
                for (int a = 1; a <= 3; a++) begin
                    do_reset(l, w, a);
                    rand_run(120, 1);
                    rand_run(120, 4);
                end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule